// File: doc/BRIEF.md
# Dual-IO DDR Flash Read Responder

This block is the memory-side engine for a two-wire double-data-rate read on a serial NOR flash. It watches chip select, the serial clock and two data lines. A transaction opens with an 8-bit read instruction. A 24-bit start address and an 8-bit mode byte follow, taken two bits on every serial clock edge. After a programmable number of latency clocks, the block streams bytes from a synchronous byte-array read port back onto both lines, two bits per edge. The address advances by one after each byte and wraps at the top.

If the mode byte's two nibbles are bitwise inverses, the block stays in a continuous-read state. The next transaction then begins straight with the address and carries no instruction. An optional training preamble fills the final four latency clocks. During it, the same 8-bit pattern bit goes out on both lines on each edge. The serial clock is oversampled by the system clock `clk`, so all state lives in one clock domain. The back-end port has one cycle of read latency.

States: IDLE (deselected), CMD (instruction), ADDR (address), MODE (mode byte), DUMMY (latency and preamble), DATA (streaming), SKIP (unsupported instruction, wait for deselect). Transitions:
- IDLE→CMD on select while continuous mode is clear.
- IDLE→ADDR on select while continuous mode is set.
- CMD→ADDR on a valid opcode after the 8th rising edge.
- CMD→SKIP on any other opcode after the 8th rising edge.
- ADDR→MODE after 12 address edges.
- MODE→DUMMY after 4 mode edges, or MODE→DATA when the latency is zero.
- DUMMY→DATA after 2×latency edges.
- Any state→IDLE on deselect.

Top module: `ddr_dual_read_resp`

## Requirements
- R1: The instruction is 8 bits, sampled MSB first on `io_in[0]` at rising `sck` edges. Only 8'hBD and 8'hBE start a read. Any other value leaves `io_oe` at 2'b00 until `cs_n` rises.
- R2: Address collection starts at the first rising edge after the instruction. The 24 address bits and then the 8 mode bits arrive two per edge on both edges, MSB first. `io_in[1]` carries the higher bit of each pair.
- R3: After the last mode edge there are `lat_cycles` full `sck` periods (2×`lat_cycles` edges). During this time `io_in` has no effect on the returned data, and `io_oe` stays 2'b00 outside the preamble.
- R4: With `pre_en` set, the last 8 latency edge-slots drive `pre_pattern` MSB first, one bit per edge, copied onto both lines with `io_oe`=2'b11. When the latency is under 4 clocks, only the final 2×`lat_cycles` bits (down to bit 0) appear.
- R5: Data starts at the slot that opens with the last latency edge. Each edge presents two bits MSB first, with `io_out[1]` the higher bit and `io_oe`=2'b11. The value set by one edge holds until the next edge.
- R6: The byte address starts at the captured address, rises by one per byte, and wraps from 24'hFFFFFF to 24'h000000.
- R7: A mode byte whose upper nibble equals the inverse of its lower nibble sets continuous mode once the transaction reaches data. After the next select, the first edges are taken as address, with no instruction.
- R8: A mode byte without that nibble relation clears continuous mode, so the next transaction must begin with an instruction.
- R9: If `cs_n` rises before the data phase (during address, mode or latency), continuous mode is cleared.
- R10: `io_oe` is 2'b00 one clock after `cs_n` is sampled high, and whenever the block is outside the preamble and data slots.
- R11: Reset clears continuous mode, returns to IDLE and drives `io_oe`=2'b00 and `io_out`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples `sck` |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, synchronous to `clk` |
| cs_n | input | 1 | Active-low chip select |
| io_in | input | 2 | Data lines as seen by the block; bit 1 carries the higher bit |
| io_out | output | 2 | Values driven onto the data lines |
| io_oe | output | 2 | Per-line output enable |
| lat_cycles | input | 4 | Latency length in `sck` periods |
| pre_en | input | 1 | Enables the training preamble |
| pre_pattern | input | 8 | Preamble pattern, sent MSB first |
| mem_addr | output | 24 | Byte address to the array read port |
| mem_rdata | input | 8 | Array read data, valid one `clk` after `mem_addr` |

## Verification
The preamble and the first data load can both fall on the same edge: the last mode edge when the latency is zero, and the last latency edge otherwise. With a short latency, a truncated preamble slot sits directly next to the first data pair. The bench runs latencies of 0 and 2 with the preamble enabled, and checks every slot against the slot index for oe, the pattern bit and the data pair. A second collision is deselect against the continuous-mode commit. `cs_n` is raised during address, during latency and in mid-data. The next transaction shows whether the block expects an instruction, which judges the commit.

// File: rtl/ddrr_pkg.sv
package ddrr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_MODE,
        ST_DUMMY,
        ST_DATA,
        ST_SKIP
    } ddrr_state_e;

    localparam logic [7:0] OPC_READ_A = 8'hBD;
    localparam logic [7:0] OPC_READ_B = 8'hBE;
    localparam int         OPC_BITS   = 8;
    localparam int         MODE_EDGES = 4;

    function automatic logic nibbles_inverse(input logic [7:0] m);
        return m[7:4] == ~m[3:0];
    endfunction

endpackage

// File: rtl/ddrr_edge_det.sv
module ddrr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
    assign fall = ~sck & sck_q;
endmodule

// File: rtl/ddrr_cont_track.sv
module ddrr_cont_track (
    input  logic clk,
    input  logic rst_n,
    input  logic txn_end,
    input  logic reached_data,
    input  logic cmpl,
    output logic cont
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cont <= 1'b0;
        else if (txn_end) cont <= reached_data & cmpl;
    end
endmodule

// File: rtl/ddr_dual_read_resp.sv
module ddr_dual_read_resp
    import ddrr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LAT_W  = 4,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic [1:0]        io_in,
    output logic [1:0]        io_out,
    output logic [1:0]        io_oe,
    input  logic [LAT_W-1:0]  lat_cycles,
    input  logic              pre_en,
    input  logic [PRE_W-1:0]  pre_pattern,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);
    localparam int ADDR_EDGES = ADDR_W / 2;
    localparam int CNT_A      = $clog2(ADDR_EDGES + 1);
    localparam int CNT_W      = (CNT_A > LAT_W + 2) ? CNT_A : LAT_W + 2;

    ddrr_state_e state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [OPC_BITS-2:0] op_q;
    logic [5:0]        mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [5:0]        sh_q;
    logic [1:0]        pair_q;
    logic              pend_q;
    logic              cont_q;

    logic rise, fall, any_edge, edge_ok;
    logic [CNT_W-1:0] dlen, s_new, pidx;
    logic [CNT_W:0]   pre_reach;
    logic [OPC_BITS-1:0] op_full;
    logic enter_data, load_byte, slot_edge, in_pre, pre_bit;

    ddrr_edge_det u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sck  (sck),
        .rise (rise),
        .fall (fall)
    );

    ddrr_cont_track u_cont (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_end     (cs_n && state_q != ST_IDLE),
        .reached_data(state_q == ST_DATA),
        .cmpl        (pend_q),
        .cont        (cont_q)
    );

    assign any_edge = rise | fall;
    assign edge_ok  = rise | (fall && cnt_q != '0);
    assign dlen     = {{(CNT_W-LAT_W-1){1'b0}}, lat_cycles, 1'b0};
    assign op_full  = {op_q, io_in[0]};
    assign mem_addr = addr_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!cs_n) state_d = cont_q ? ST_ADDR : ST_CMD;
            ST_CMD:   if (rise && cnt_q == CNT_W'(OPC_BITS-1))
                          state_d = (op_full == OPC_READ_A || op_full == OPC_READ_B)
                                    ? ST_ADDR : ST_SKIP;
            ST_ADDR:  if (edge_ok && cnt_q == CNT_W'(ADDR_EDGES-1)) state_d = ST_MODE;
            ST_MODE:  if (any_edge && cnt_q == CNT_W'(MODE_EDGES-1))
                          state_d = (dlen == '0) ? ST_DATA : ST_DUMMY;
            ST_DUMMY: if (any_edge && (cnt_q + 1'b1) == dlen) state_d = ST_DATA;
            ST_DATA:  state_d = ST_DATA;
            ST_SKIP:  state_d = ST_SKIP;
            default:  state_d = ST_IDLE;
        endcase
        if (cs_n) state_d = ST_IDLE;
    end

    assign enter_data = !cs_n && (state_q == ST_MODE || state_q == ST_DUMMY)
                        && state_d == ST_DATA;
    assign load_byte  = enter_data || (!cs_n && state_q == ST_DATA && any_edge && pair_q == 2'd0);

    // slot index of the latency slot opened by this edge
    assign slot_edge  = !cs_n && any_edge && !enter_data &&
                        (state_q == ST_DUMMY ||
                         (state_q == ST_MODE && cnt_q == CNT_W'(MODE_EDGES-1)));
    assign s_new      = (state_q == ST_MODE) ? '0 : cnt_q + 1'b1;
    assign pre_reach  = {1'b0, s_new} + (CNT_W+1)'(PRE_W);
    assign in_pre     = pre_en && (pre_reach >= {1'b0, dlen});
    assign pidx       = dlen - s_new - 1'b1;

    always_comb begin
        pre_bit = 1'b0;
        for (int i = 0; i < PRE_W; i++) begin
            if (pidx == CNT_W'(i)) pre_bit = pre_pattern[i];
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            op_q    <= '0;
            mode_q  <= '0;
            addr_q  <= '0;
            sh_q    <= '0;
            pair_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cs_n) begin
                cnt_q  <= '0;
                pair_q <= '0;
            end else begin
                unique case (state_q)
                    ST_CMD: if (rise) begin
                        op_q  <= op_full[OPC_BITS-2:0];
                        cnt_q <= (cnt_q == CNT_W'(OPC_BITS-1)) ? '0 : cnt_q + 1'b1;
                    end
                    ST_ADDR: if (edge_ok) begin
                        addr_q <= {addr_q[ADDR_W-3:0], io_in[1], io_in[0]};
                        cnt_q  <= (cnt_q == CNT_W'(ADDR_EDGES-1)) ? '0 : cnt_q + 1'b1;
                    end
                    ST_MODE: if (any_edge) begin
                        mode_q <= {mode_q[3:0], io_in};
                        if (cnt_q == CNT_W'(MODE_EDGES-1)) begin
                            pend_q <= nibbles_inverse({mode_q, io_in});
                            cnt_q  <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DUMMY: if (any_edge) cnt_q <= cnt_q + 1'b1;
                    default: ;
                endcase
                if (load_byte) begin
                    sh_q   <= mem_rdata[5:0];
                    addr_q <= addr_q + 1'b1;
                end else if (state_q == ST_DATA && any_edge) begin
                    sh_q <= {sh_q[3:0], 2'b00};
                end
                if (enter_data)                         pair_q <= 2'd1;
                else if (state_q == ST_DATA && any_edge) pair_q <= pair_q + 1'b1;
            end
        end
    end

    // line drivers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_oe  <= 2'b00;
            io_out <= 2'b00;
        end else if (cs_n) begin
            io_oe <= 2'b00;
        end else if (load_byte) begin
            io_oe  <= 2'b11;
            io_out <= mem_rdata[7:6];
        end else if (state_q == ST_DATA && any_edge) begin
            io_out <= sh_q[5:4];
        end else if (slot_edge) begin
            if (in_pre) begin
                io_oe  <= 2'b11;
                io_out <= {2{pre_bit}};
            end else begin
                io_oe <= 2'b00;
            end
        end
    end
endmodule

// File: rtl/ddrr_checker.sv
module ddrr_checker
    import ddrr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              cs_n,
    input logic [1:0]        io_out,
    input logic [1:0]        io_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input ddrr_state_e       state,
    input logic              cont
);
    p_oe_off_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> io_oe == 2'b00);

    p_oe_only_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe != 2'b00) |-> (state == ST_DUMMY || state == ST_DATA));

    p_cont_at_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cont) |-> $past(cs_n));

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) == ST_DATA && !$stable(mem_addr))
        |-> mem_addr == $past(mem_addr) + 1'b1);

    p_out_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(io_out) |-> ($past(sck) != $past(sck, 2)));

    p_idle_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && cs_n) |-> state == ST_IDLE);
endmodule

bind ddr_dual_read_resp ddrr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck     (sck),
    .cs_n    (cs_n),
    .io_out  (io_out),
    .io_oe   (io_oe),
    .mem_addr(mem_addr),
    .state   (state_q),
    .cont    (cont_q)
);

// File: tb/ddr_dual_read_resp_tb.sv
module ddr_dual_read_resp_tb;
    logic        clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1;
    logic [1:0]  io_in = 2'b00;
    logic [1:0]  io_out, io_oe;
    logic [3:0]  lat_cycles = 4'd0;
    logic        pre_en = 1'b0;
    logic [7:0]  pre_pattern = 8'hD2;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata;

    int checks = 0, fails = 0;
    bit cont_m = 1'b0;

    always #10 clk = ~clk;

    ddr_dual_read_resp u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .lat_cycles(lat_cycles), .pre_en(pre_en), .pre_pattern(pre_pattern),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mem_f(input logic [23:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'hC3;
    endfunction

    always_ff @(posedge clk) mem_rdata <= mem_f(mem_addr);

    typedef struct packed {
        logic        cmd;
        logic [7:0]  op;
        logic [23:0] addr;
        logic [7:0]  mode;
        logic [3:0]  lat;
        logic        pre;
        logic [3:0]  nb;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'hBD, 24'h000010, 8'h00, 4'd4, 1'b1, 4'd3},
        '{1'b1, 8'hBE, 24'h123456, 8'hA5, 4'd6, 1'b1, 4'd2},
        '{1'b0, 8'h00, 24'hFFFFFE, 8'h5A, 4'd5, 1'b0, 4'd4},
        '{1'b0, 8'h00, 24'h00ABCD, 8'h12, 4'd8, 1'b1, 4'd2},
        '{1'b1, 8'h03, 24'h000040, 8'h00, 4'd4, 1'b1, 4'd2},
        '{1'b1, 8'hBD, 24'h7FFFFF, 8'hF0, 4'd0, 1'b1, 4'd3},
        '{1'b0, 8'h00, 24'h000100, 8'h0F, 4'd2, 1'b1, 4'd2},
        '{1'b0, 8'h00, 24'h00FFFF, 8'h00, 4'd3, 1'b0, 4'd2}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (3) @(negedge clk);
    endtask

    // stop_at > 0 raises cs_n before post-instruction edge number stop_at
    task automatic run_txn(input bit cmd, input logic [7:0] op, input logic [23:0] a,
                           input logic [7:0] m, input logic [3:0] L, input bit pre,
                           input int nb, input int stop_at, input string tag);
        bit resp, cmpl;
        int li, total, bad_lat, bad_dat;
        logic [3:0] al, el, ad, ed, got, exp;
        li = int'(L);
        resp = cmd ? (op == 8'hBD || op == 8'hBE) : cont_m;
        cmpl = (m[7:4] == ~m[3:0]);
        bad_lat = 0; bad_dat = 0;
        al = '0; el = '0; ad = '0; ed = '0;
        lat_cycles = L; pre_en = pre;
        @(negedge clk); cs_n = 1'b0; half();
        if (cmd) begin
            for (int i = 7; i >= 0; i--) begin
                io_in = {1'b0, op[i]};
                sck = 1'b1; half();
                sck = 1'b0; half();
            end
        end
        total = 16 + 2*li + 4*nb;
        for (int e = 0; e < total; e++) begin
            if (stop_at > 0 && e == stop_at) break;
            if (e < 12)      io_in = a[23-2*e -: 2];
            else if (e < 16) io_in = m[7-2*(e-12) -: 2];
            else             io_in = 2'(e);   // ignored lines (R3)
            sck = ~sck; half();
            if (stop_at == 0 && e >= 15 && e <= 14 + 2*li + 4*nb) begin
                int s;
                s = e - 15;
                got = {io_oe, io_out};
                if (!resp) begin
                    exp = 4'b0000;
                    if (io_oe != 2'b00) begin bad_dat++; ad = got; ed = exp; end
                end else if (s < 2*li) begin
                    if (pre && s + 8 >= 2*li) exp = {2'b11, {2{pre_pattern[2*li-1-s]}}};
                    else                      exp = 4'b0000;
                    if (exp[3:2] == 2'b00 ? (io_oe != 2'b00) : (got != exp)) begin
                        if (bad_lat == 0) begin al = got; el = exp; end
                        bad_lat++;
                    end
                end else begin
                    int k;
                    logic [7:0] b;
                    k = s - 2*li;
                    b = mem_f(a + 24'(k/4));
                    exp = {2'b11, 2'(b >> (6 - 2*(k%4)))};
                    if (got != exp) begin
                        if (bad_dat == 0) begin ad = got; ed = exp; end
                        bad_dat++;
                    end
                end
            end
        end
        cs_n = 1'b1; half();
        sck = 1'b0; half();
        check(io_oe == 2'b00, {"R10 oe off after deselect ", tag}, 32'(io_oe), 32'h0);
        if (stop_at == 0) begin
            if (!resp) begin
                check(bad_dat == 0, {"R1 R8 no drive after rejected opcode ", tag}, 32'(ad), 32'(ed));
            end else begin
                check(bad_lat == 0, {"R3 R4 latency/preamble slots ", tag}, 32'(al), 32'(el));
                check(bad_dat == 0, {"R2 R5 R6 data slots ", tag}, 32'(ad), 32'(ed));
            end
        end
        if (stop_at == 0 || stop_at > 15 + 2*li) cont_m = resp && cmpl;
        else                                     cont_m = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(io_oe == 2'b00 && io_out == 2'b00, "R11 reset outputs", 32'({io_oe, io_out}), 32'h0);
        rst_n = 1'b1;
        half();
        check(io_oe == 2'b00, "R11 idle after reset", 32'(io_oe), 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            run_txn(v.cmd, v.op, v.addr, v.mode, v.lat, v.pre, int'(v.nb), 0,
                    v.cmd ? "instr" : "R7 continuous");
        end

        // R9: deselect during address clears continuous mode
        run_txn(1'b1, 8'hBD, 24'h000200, 8'hC3, 4'd4, 1'b1, 2, 0, "enter cont");
        run_txn(1'b0, 8'h00, 24'h000000, 8'hA5, 4'd4, 1'b0, 2, 6, "abort addr");
        run_txn(1'b1, 8'hBE, 24'h000300, 8'h00, 4'd4, 1'b0, 2, 0, "R9 after addr abort");

        // R9: deselect during latency clears continuous mode
        run_txn(1'b1, 8'hBD, 24'h000400, 8'h96, 4'd6, 1'b0, 1, 0, "enter cont");
        run_txn(1'b0, 8'h00, 24'h000500, 8'hA5, 4'd6, 1'b1, 1, 18, "abort dummy");
        run_txn(1'b1, 8'hBD, 24'h010000, 8'h00, 4'd3, 1'b1, 2, 0, "R9 after dummy abort");

        // R10: deselect in mid-data drops the enables
        run_txn(1'b1, 8'hBD, 24'h000600, 8'h00, 4'd2, 1'b0, 3, 23, "R10 mid-data");

        // R11: reset in mid-transaction clears continuous mode
        run_txn(1'b1, 8'hBE, 24'h000700, 8'h69, 4'd4, 1'b0, 1, 0, "enter cont");
        @(negedge clk); cs_n = 1'b0; half();
        sck = 1'b1; half();
        rst_n = 1'b0; half();
        check(io_oe == 2'b00 && io_out == 2'b00, "R11 outputs in reset", 32'({io_oe, io_out}), 32'h0);
        sck = 1'b0; cs_n = 1'b1; half();
        rst_n = 1'b1; half();
        cont_m = 1'b0;
        run_txn(1'b1, 8'hBD, 24'h000800, 8'h00, 4'd4, 1'b1, 2, 0, "R11 instr after reset");

        finish_run();
    end
endmodule